// File: doc/BRIEF.md
# Successive-Approximation Controller with Unit-Capacitor Switch Decoder

This block runs the digital side of a 12-bit successive-approximation converter. The DAC it drives has two parts. The coarse part is an array of 32 identical unit capacitors. The fine part is a resistor string with 128 taps. A start strobe opens a sampling window, during which every unit capacitor is tied to the analog input. After that, the block resolves one result bit per clock, starting at the top bit, using a single comparator decision each cycle.

For each trial code, the upper five bits choose how many units sit on the full reference. The unit just past that boundary is wired to the resistor-string tap. The lower seven bits give the tap index. All other units go to ground. Because the units are identical, stepping the code by one LSB never reshuffles which capacitors are already on the reference.

When the last decision is made, the block raises a one-cycle done pulse and presents the 12-bit word. The switch pattern then holds the final code until the next start.

Top module: `sar_unitcap_ctrl`

## Requirements
- R1: After reset, busy_o, sample_o and done_o are 0 and result_o is 0. The switches show code 0: unit 0 carries the tap code, every other unit carries the ground code, and tap_o is 0.
- R2: Each unit has a 2-bit switch code at unit_sel_o[2i+1:2i]: 00 ground, 01 reference, 10 resistor tap, 11 analog input. Consider a start_i pulse while the block is idle. For the next SAMPLE_CYCLES cycles (default 2), sample_o and busy_o are 1 and every unit code is 11.
- R3: The first cycle after sampling presents trial code 0x800. This puts units 0..15 on the reference and unit 16 on the tap, with sample_o at 0.
- R4: Outside sampling, let V be bits 11:7 of the trial code. Units 0..V-1 carry 01, unit V carries 10, and all higher units carry 00. Exactly one unit carries 10.
- R5: tap_o always equals bits 6:0 of the current trial code.
- R6: Bits are tested from 11 down to 0, one per clock. If cmp_i is 1 (input above the trial level), the tested bit stays 1; otherwise it is cleared. The next lower bit is set for the following trial. For example, from 0x800 the next trial is 0xC00 (24 units on reference, unit 24 on tap) or 0x400 (8 units, unit 8 on tap).
- R7: done_o is high for exactly one cycle, in the cycle after the 12th decision. In that cycle busy_o is 0 and result_o holds the final code. result_o changes at no other time.
- R8: A start_i pulse that arrives while busy_o is 1 is ignored. The running conversion continues unchanged and does not return to sampling.
- R9: While idle with no start, unit_sel_o, tap_o and result_o keep the final code of the last conversion.
- R10: With an ideal comparator (cmp_i = 1 when the input code is at least the DAC level), every input code from 0 to 4095 converts to itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion start strobe |
| cmp_i | input | 1 | Comparator decision, 1 when input exceeds trial level |
| unit_sel_o | output | 64 | 2-bit switch code per unit capacitor |
| tap_o | output | 7 | Resistor-string tap index |
| sample_o | output | 1 | Sampling window active |
| busy_o | output | 1 | Sampling or conversion in progress |
| done_o | output | 1 | One-cycle end-of-conversion pulse |
| result_o | output | 12 | Converted code |

## Verification
The hardest cases to reach are the code boundaries where the thermometer count changes. At these points every lower bit flips, as in 0x07F to 0x080, and a wrong tap unit or off-by-one boundary would show up there. The bench reaches them by sweeping every input code through a behavioural model of the array and string. That model derives the comparator decision from the switch pattern the block actually drives. On selected codes it also compares the full switch pattern at every step against the thermometer rule. A start pulse injected in the middle of a conversion exercises the ignore path.

// File: rtl/sar_unitcap_ctrl.sv
module sar_unitcap_ctrl #(
  parameter int NBITS         = 12,
  parameter int CBITS         = 5,
  parameter int SAMPLE_CYCLES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic                        cmp_i,
  output logic [2*(1<<CBITS)-1:0]     unit_sel_o,
  output logic [NBITS-CBITS-1:0]      tap_o,
  output logic                        sample_o,
  output logic                        busy_o,
  output logic                        done_o,
  output logic [NBITS-1:0]            result_o
);
  localparam int RBITS = NBITS - CBITS;
  localparam int UNITS = 1 << CBITS;
  localparam int IW    = $clog2(NBITS);
  localparam int SW    = (SAMPLE_CYCLES > 1) ? $clog2(SAMPLE_CYCLES) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_SAMP, ST_CONV} st_t;

  st_t              st;
  logic [SW-1:0]    scnt;
  logic [IW-1:0]    bidx;
  logic [NBITS-1:0] trial;
  logic [NBITS-1:0] res;
  logic             done_q;
  logic [CBITS-1:0] vcoarse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      scnt   <= '0;
      bidx   <= '0;
      trial  <= '0;
      res    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (start_i) begin
          st   <= ST_SAMP;
          scnt <= '0;
        end
        ST_SAMP: if (scnt == SW'(SAMPLE_CYCLES - 1)) begin
          st    <= ST_CONV;
          trial <= {1'b1, {(NBITS-1){1'b0}}};
          bidx  <= IW'(NBITS - 1);
        end else begin
          scnt <= scnt + 1'b1;
        end
        ST_CONV: begin
          trial[bidx] <= cmp_i;
          if (bidx == '0) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
            res    <= {trial[NBITS-1:1], cmp_i};
          end else begin
            trial[bidx - 1'b1] <= 1'b1;
            bidx <= bidx - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign vcoarse  = trial[NBITS-1:RBITS];
  assign tap_o    = trial[RBITS-1:0];
  assign sample_o = (st == ST_SAMP);
  assign busy_o   = (st != ST_IDLE);
  assign done_o   = done_q;
  assign result_o = res;

  for (genvar i = 0; i < UNITS; i++) begin : g_unit
    localparam logic [CBITS-1:0] UI = CBITS'(i);
    assign unit_sel_o[2*i +: 2] = sample_o      ? 2'b11 :
                                  (UI < vcoarse) ? 2'b01 :
                                  (UI == vcoarse) ? 2'b10 : 2'b00;
  end
endmodule

// File: rtl/sar_unitcap_ctrl_chk.sv
module sar_unitcap_ctrl_chk #(
  parameter int UNITS = 32,
  parameter int TW    = 7,
  parameter int NBITS = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic [2*UNITS-1:0] unit_sel_o,
  input logic [TW-1:0]      tap_o,
  input logic               sample_o,
  input logic               busy_o,
  input logic               done_o,
  input logic [NBITS-1:0]   result_o
);
  logic [UNITS-1:0] tapf;
  for (genvar i = 0; i < UNITS; i++) begin : g_f
    assign tapf[i] = unit_sel_o[2*i+1] & ~unit_sel_o[2*i];
  end

  AST_SAMPLE_ALL_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> (&unit_sel_o)); // R2
  AST_START_ENTERS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && sample_o)); // R2
  AST_ONE_TAP_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_o |-> ($countones(tapf) == 1)); // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R7
  AST_RESULT_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_o) |-> done_o); // R7
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !sample_o && start_i) |=> !sample_o); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(unit_sel_o) && $stable(tap_o))); // R9
endmodule

bind sar_unitcap_ctrl sar_unitcap_ctrl_chk #(
  .UNITS(1 << CBITS), .TW(NBITS - CBITS), .NBITS(NBITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .unit_sel_o(unit_sel_o),
  .tap_o(tap_o), .sample_o(sample_o), .busy_o(busy_o), .done_o(done_o),
  .result_o(result_o)
);

// File: tb/sar_unitcap_ctrl_bench.sv
`timescale 1ns/1ps
module sar_unitcap_ctrl_bench;
  localparam int UNITS = 32;
  localparam int SAMP  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        cmp_i;
  logic [63:0] unit_sel_o;
  logic [6:0]  tap_o;
  logic        sample_o, busy_o, done_o;
  logic [11:0] result_o;

  int total = 0;
  int fails = 0;
  bit finished = 0;
  int vin = 0;

  always #4 clk = ~clk;

  sar_unitcap_ctrl u_sar_unitcap_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
    .unit_sel_o(unit_sel_o), .tap_o(tap_o), .sample_o(sample_o),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  // ideal array + string: each reference unit is 128 LSB, the tap unit adds tap_o
  int level;
  always_comb begin
    int nref, ntap;
    nref = 0; ntap = 0;
    for (int u = 0; u < UNITS; u++) begin
      if (unit_sel_o[2*u +: 2] == 2'b01) nref++;
      if (unit_sel_o[2*u +: 2] == 2'b10) ntap++;
    end
    level = nref * 128 + ((ntap == 1) ? int'(tap_o) : 0);
    cmp_i = (vin >= level);
  end

  function automatic logic [63:0] thermo(input logic [11:0] c);
    logic [63:0] p;
    int v;
    v = int'(c[11:7]);
    for (int u = 0; u < UNITS; u++)
      p[2*u +: 2] = (u < v) ? 2'b01 : (u == v) ? 2'b10 : 2'b00;
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_conv(input logic [11:0] code, input bit steps, input int poke_b);
    logic [11:0] exp;
    @(negedge clk); vin = int'(code); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (int k = 0; k < SAMP; k++) begin
      if (steps) begin
        chk(sample_o && busy_o, "R2 sample/busy", {62'd0, sample_o, busy_o}, 64'd3);
        chk(unit_sel_o == '1, "R2 all input", unit_sel_o, '1);
      end
      @(negedge clk);
    end
    exp = 12'h800;
    for (int b = 11; b >= 0; b--) begin
      if (steps) begin
        if (b == 11) chk(!sample_o && unit_sel_o == thermo(12'h800), "R3 first trial", unit_sel_o, thermo(12'h800));
        chk(unit_sel_o == thermo(exp), (b == 11) ? "R4 pattern" : "R6 pattern", unit_sel_o, thermo(exp));
        chk(tap_o == exp[6:0], "R5 tap", 64'(tap_o), 64'(exp[6:0]));
        if (poke_b >= 0 && b < poke_b)
          chk(!sample_o && busy_o, "R8 no restart", {62'd0, sample_o, busy_o}, 64'd1);
      end
      start_i = (b == poke_b);
      exp[b] = (int'(code) >= int'(exp));
      if (b > 0) exp[b-1] = 1'b1;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(done_o && !busy_o, "R7 done", {62'd0, done_o, busy_o}, 64'd2);
    chk(result_o == code, "R10 result", 64'(result_o), 64'(code));
    @(negedge clk);
    chk(!done_o, "R7 single pulse", 64'(done_o), 64'd0);
  endtask

  task automatic t_reset();
    chk(!busy_o && !sample_o && !done_o, "R1 flags", {61'd0, busy_o, sample_o, done_o}, 64'd0);
    chk(result_o == 12'd0, "R1 result", 64'(result_o), 64'd0);
    chk(unit_sel_o == thermo(12'd0) && tap_o == 7'd0, "R1 switches", unit_sel_o, thermo(12'd0));
  endtask

  task automatic t_first_decision();
    // full-scale: bit 11 kept, next trial 0xC00 -> 24 units on ref, unit 24 tap
    @(negedge clk); vin = 4095; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (SAMP + 1) @(negedge clk);
    chk(unit_sel_o[47:0] == {48{1'b0}} + {24{2'b01}} && unit_sel_o[49:48] == 2'b10,
        "R6 keep bit", unit_sel_o, thermo(12'hC00));
    repeat (12) @(negedge clk);
    chk(result_o == 12'hFFF, "R10 full scale", 64'(result_o), 64'hFFF);
    // zero: bit 11 cleared, next trial 0x400 -> 8 units on ref, unit 8 tap
    @(negedge clk); vin = 0; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (SAMP + 1) @(negedge clk);
    chk(unit_sel_o == thermo(12'h400) && unit_sel_o[17:16] == 2'b10, "R6 clear bit", unit_sel_o, thermo(12'h400));
    repeat (12) @(negedge clk);
    chk(result_o == 12'h000, "R10 zero", 64'(result_o), 64'h0);
  endtask

  task automatic t_steps();
    run_conv(12'h07F, 1, -1);
    run_conv(12'h080, 1, -1);
    run_conv(12'hA5C, 1, -1);
  endtask

  task automatic t_busy_ignore();
    run_conv(12'h5A3, 1, 6);
    run_conv(12'h3E1, 1, 11);
  endtask

  task automatic t_hold();
    run_conv(12'h3C5, 0, -1);
    repeat (4) @(negedge clk);
    chk(unit_sel_o == thermo(12'h3C5), "R9 switches hold", unit_sel_o, thermo(12'h3C5));
    chk(tap_o == 7'h45, "R9 tap hold", 64'(tap_o), 64'h45);
    chk(result_o == 12'h3C5 && !busy_o && !sample_o, "R9 result hold", 64'(result_o), 64'h3C5);
  endtask

  task automatic t_ramp();
    int bad = 0;
    for (int c = 0; c < 4096; c++) begin
      run_conv(12'(c), 0, -1);
    end
    bad = bad;
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_decision();
    t_steps();
    t_busy_ignore();
    t_hold();
    t_ramp();
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule